// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width modulated waveform. Software programs it through a small register bus: a mode word, a duty value, a period value, a read-only view of the running counter and an update register. The counter advances on a tick taken from a power-of-two divider of the system clock or from one of two externally supplied clock enables. It runs either as a sawtooth, giving a left-aligned waveform, or as a triangle, giving a center-aligned waveform. A mode bit sets the level the output takes at the start of each period.

A value written to the update register is not applied at once. It is held in a shadow register and copied into the duty or the period only when the next period begins. Firmware can therefore change the waveform while it runs and never produce a truncated or stretched pulse. The duty and period registers can still be written directly when the channel is idle. The block drives the waveform, a one-cycle pulse that marks each period start, and the live counter value.

Top module: `pwm_channel`

## Requirements
- R1: After reset, every register and the counter read 0, `period_start` is low and `pwm_out` is high (the idle level for polarity 0).
- R2: Register addresses: mode at 0x00, duty at 0x04, period at 0x08, counter at 0x0C, update at 0x10. Mode bits [3:0] hold the clock select, bit 8 the alignment (1 = center), bit 9 the active polarity and bit 10 the update target. All other mode bits read 0. Writes to the counter address are ignored. Any other address reads 0.
- R3: A clock select n from 0 to 10 gives one counter tick every 2^n clock cycles. Select 11 ticks on `aux_a_en` and select 12 ticks on `aux_b_en`. Selects 13 to 15 give no ticks.
- R4: In left-aligned mode the counter runs 0 to P-1 and wraps, so a period lasts P ticks. `period_start` is high for one cycle, the first cycle the counter shows 0 in each new period. With P = 0 the counter stays at 0.
- R5: In center-aligned mode the counter climbs from 0 to P and falls back to 0, so a period lasts 2·P ticks.
- R6: While enabled, `pwm_out` equals mode bit 9 when the counter is below the duty value and the inverse otherwise. The same compare applies on the rising and the falling slope.
- R7: A duty of 0 holds `pwm_out` at the inverse of bit 9. A nonzero duty of at least P holds it at bit 9, in both alignments.
- R8: Writing the update register while bit 10 is 0 replaces the duty at the next period start. The duty register reads its old value until then.
- R9: Writing the update register while bit 10 is 1 replaces the period at the next period start. The period register reads its old value until then.
- R10: A pending update is applied once only. A direct duty write made after the commit is not overwritten at later period starts.
- R11: While `en` is low the counter reads 0, `pwm_out` sits at the inverse of bit 9 and no `period_start` occurs. After `en` rises the counter resumes counting from 0.
- R12: Reading the update address returns the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Channel run enable |
| aux_a_en | input | 1 | First external tick enable |
| aux_b_en | input | 1 | Second external tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| pwm_out | output | 1 | Waveform output |
| period_start | output | 1 | One-cycle pulse at each new period |
| count_out | output | 32 | Live counter value |

## Verification
The embedded properties watch invariants on every cycle: the counter is forced to zero while the channel is disabled, every period-start pulse coincides with a zero count, a divide-by-two select never ticks twice in a row, a pending update is cleared by the period start that consumes it, and the duty holds still unless it is written or committed. The bench scenarios are the only place that the waveform itself is measured. They count active cycles and period starts over whole periods for both alignments, the prescaler and auxiliary tick sources, and the duty extremes. They also follow the read-back sequence that shows a buffered update landing exactly at a period boundary and only once.

// File: rtl/pwm_ch_pkg.sv
// Package: shared types and address decode for the PWM channel.
// Assumes a 5-bit byte address with registers on 4-byte boundaries.
package pwm_ch_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        REG_MODE,
        REG_DUTY,
        REG_PER,
        REG_CNT,
        REG_UPD,
        REG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic       upd_per;   // update target: 0 duty, 1 period
        logic       pol;       // active level at period start
        logic       center;    // 1 = triangle counting
        logic [3:0] clk_sel;   // tick source select
    } mode_t;

    // Map a byte address to a register selector
    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            5'h00:   return REG_MODE;
            5'h04:   return REG_DUTY;
            5'h08:   return REG_PER;
            5'h0C:   return REG_CNT;
            5'h10:   return REG_UPD;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tick_sel.sv
// Tick source selector: a free-running divider offers ticks at 2^n
// cycle intervals for n = 0..DIV_STEPS; two further selects pass the
// external enables through; remaining selects give no tick.
// Assumes the external enables are synchronous to clk.
module pwm_tick_sel #(
    parameter int DIV_STEPS = 10,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             aux_a_en,
    input  logic             aux_b_en,
    output logic             tick
);
    localparam logic [SEL_W-1:0] SEL_DIV_MAX = SEL_W'(DIV_STEPS);
    localparam logic [SEL_W-1:0] SEL_AUX_A   = SEL_W'(DIV_STEPS + 1);
    localparam logic [SEL_W-1:0] SEL_AUX_B   = SEL_W'(DIV_STEPS + 2);

    logic [DIV_STEPS-1:0] pre_q;
    logic [DIV_STEPS:0]   div_hit;

    // Free-running prescale counter
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    assign div_hit[0] = 1'b1;
    genvar gi;
    generate
        for (gi = 1; gi <= DIV_STEPS; gi++) begin : g_div
            assign div_hit[gi] = &pre_q[gi-1:0];
        end
    endgenerate

    // Pick the tick source named by the select
    always_comb begin
        if (sel <= SEL_DIV_MAX)    tick = div_hit[sel];
        else if (sel == SEL_AUX_A) tick = aux_a_en;
        else if (sel == SEL_AUX_B) tick = aux_b_en;
        else                       tick = 1'b0;
    end

    // R3
    div2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_W'(1) && tick) |=> !(sel == SEL_W'(1) && tick));

endmodule

// File: rtl/pwm_regs.sv
// Register file: mode, duty and period storage, the update shadow with
// its pending flag, and combinational read-back. A pending update is
// committed on the wrap strobe from the counter. A direct write in the
// same cycle as a commit wins over the commit.
module pwm_regs
    import pwm_ch_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wrap,
    input  logic [DATA_W-1:0] cnt,
    output mode_t             mode,
    output logic [DATA_W-1:0] duty,
    output logic [DATA_W-1:0] period
);
    localparam int MODE_W = $bits(mode_t);

    reg_sel_e          sel;
    logic [DATA_W-1:0] shadow_q;
    logic              pend_q;
    logic              tgt_q;
    logic              upd_wr;

    assign sel    = decode_addr(bus_addr);
    assign upd_wr = bus_wr && (sel == REG_UPD);

    // Register writes and shadow commit at period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            duty     <= '0;
            period   <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
            tgt_q    <= 1'b0;
        end else begin
            if (wrap && pend_q) begin
                if (tgt_q) period <= shadow_q;
                else       duty   <= shadow_q;
                pend_q <= 1'b0;
            end
            if (bus_wr) begin
                case (sel)
                    REG_MODE: mode <= '{upd_per: bus_wdata[10],
                                        pol:     bus_wdata[9],
                                        center:  bus_wdata[8],
                                        clk_sel: bus_wdata[3:0]};
                    REG_DUTY: duty <= bus_wdata;
                    REG_PER:  period <= bus_wdata;
                    REG_UPD: begin
                        shadow_q <= bus_wdata;
                        pend_q   <= 1'b1;
                        tgt_q    <= mode.upd_per;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read-back multiplexer
    always_comb begin
        case (sel)
            REG_MODE: bus_rdata = DATA_W'({mode.upd_per, mode.pol, mode.center,
                                           4'b0000, mode.clk_sel});
            REG_DUTY: bus_rdata = duty;
            REG_PER:  bus_rdata = period;
            REG_CNT:  bus_rdata = cnt;
            REG_UPD:  bus_rdata = shadow_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R10
    pend_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !upd_wr) |=> !pend_q);

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wrap && pend_q && !tgt_q) && !(bus_wr && sel == REG_DUTY))
        |=> $stable(duty));

    // R9
    per_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pend_q && tgt_q && !(bus_wr && sel == REG_PER))
        |=> (period == $past(shadow_q)));

    initial begin
        // R2
        mode_width_chk: assert (MODE_W == 7);
    end

endmodule

// File: rtl/pwm_wave_core.sv
// Waveform core: sawtooth or triangle counter advanced by tick, the
// period-end strobe, the registered period-start pulse and the duty
// compare. Assumes duty and period are stable apart from commits that
// coincide with the wrap strobe.
module pwm_wave_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              center,
    input  logic              pol,
    input  logic [DATA_W-1:0] duty,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap,
    output logic              period_start,
    output logic              pwm_out
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic down_q;
    logic per_zero;
    logic end_left;
    logic end_center;
    logic active;

    assign per_zero   = (period == '0);
    assign end_left   = !center && (cnt >= period - ONE);
    assign end_center = center && (cnt <= ONE) && (down_q || cnt >= period);

    // Period end: the tick that returns the counter to zero
    always_comb begin
        wrap = en && tick && (per_zero || end_left || end_center);
    end

    // Counter and slope direction
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            down_q <= 1'b0;
        end else if (tick) begin
            if (per_zero) begin
                cnt    <= '0;
                down_q <= 1'b0;
            end else if (!center) begin
                cnt    <= end_left ? '0 : cnt + ONE;
                down_q <= 1'b0;
            end else if (!down_q) begin
                if (cnt >= period) begin
                    cnt    <= cnt - ONE;
                    down_q <= (cnt > ONE);
                end else begin
                    cnt <= cnt + ONE;
                end
            end else begin
                if (cnt <= ONE) begin
                    cnt    <= '0;
                    down_q <= 1'b0;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    // Period-start pulse, aligned with the first zero count
    always_ff @(posedge clk) begin
        if (!rst_n) period_start <= 1'b0;
        else        period_start <= wrap;
    end

    // Duty compare, saturating to full-on when duty reaches the period
    always_comb begin
        active  = (duty != '0) && ((cnt < duty) || (duty >= period));
        pwm_out = (en && active) ? pol : ~pol;
    end

    // R11
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    // R4
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (cnt == '0));

    // R5
    center_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && center && !per_zero && tick && down_q && cnt > ONE)
        |=> (!en || cnt == $past(cnt) - ONE));

    // R7
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> (pwm_out == ~pol));

endmodule

// File: rtl/pwm_channel.sv
// Top: one double-buffered PWM channel. Connects the tick selector,
// register file and waveform core. Synchronous active-low reset.
module pwm_channel
    import pwm_ch_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DIV_STEPS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              aux_a_en,
    input  logic              aux_b_en,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              period_start,
    output logic [DATA_W-1:0] count_out
);
    mode_t             mode;
    logic [DATA_W-1:0] duty;
    logic [DATA_W-1:0] period;
    logic [DATA_W-1:0] cnt;
    logic              tick;
    logic              wrap;

    pwm_tick_sel #(
        .DIV_STEPS(DIV_STEPS),
        .SEL_W    (4)
    ) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (mode.clk_sel),
        .aux_a_en(aux_a_en),
        .aux_b_en(aux_b_en),
        .tick    (tick)
    );

    pwm_regs #(
        .DATA_W(DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .wrap     (wrap),
        .cnt      (cnt),
        .mode     (mode),
        .duty     (duty),
        .period   (period)
    );

    pwm_wave_core #(
        .DATA_W(DATA_W)
    ) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .tick        (tick),
        .center      (mode.center),
        .pol         (mode.pol),
        .duty        (duty),
        .period      (period),
        .cnt         (cnt),
        .wrap        (wrap),
        .period_start(period_start),
        .pwm_out     (pwm_out)
    );

    assign count_out = cnt;

endmodule

// File: tb/pwm_channel_tb.sv
// Directed bench for pwm_channel: one task per scenario.
module pwm_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic        aux_on;
    logic [1:0]  aux_ph;
    logic        aux_a_en;
    logic        aux_b_en;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    logic        period_start;
    logic [31:0] count_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwm_channel dut_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .aux_a_en(aux_a_en), .aux_b_en(aux_b_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out),
        .period_start(period_start), .count_out(count_out)
    );

    // external enable: one pulse every third cycle when running
    always @(negedge clk) begin
        if (!rst_n)            aux_ph <= 2'd0;
        else if (aux_ph == 2)  aux_ph <= 2'd0;
        else                   aux_ph <= aux_ph + 2'd1;
    end
    assign aux_a_en = aux_on && (aux_ph == 2'd0);
    assign aux_b_en = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int n, input logic pol, output int act, output int st);
        act = 0; st = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out == pol) act++;
            if (period_start)  st++;
        end
    endtask

    task automatic wait_start();
        int guard = 0;
        @(negedge clk);
        while (!period_start && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic config_ch(input logic [31:0] m, input logic [31:0] p,
                             input logic [31:0] d);
        en = 1'b0;
        wr(5'h00, m);
        wr(5'h08, p);
        wr(5'h04, d);
        @(negedge clk);
        en = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(5'(a * 4), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(pwm_out == 1'b1, "R1 idle output", 32'(pwm_out), 1);
        chk(period_start == 1'b0, "R1 no start", 32'(period_start), 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v);
        chk(v == 32'h70F, "R2 mode fields", v, 32'h70F);
        wr(5'h0C, 32'h55);
        rd(5'h0C, v);
        chk(v == 0, "R2 counter write ignored", v, 0);
        rd(5'h14, v);
        chk(v == 0, "R2 unmapped 0x14", v, 0);
        rd(5'h03, v);
        chk(v == 0, "R2 unmapped 0x03", v, 0);
        wr(5'h00, 32'h0);
        wr(5'h10, 32'hABCD);
        rd(5'h10, v);
        chk(v == 32'hABCD, "R12 update readback", v, 32'hABCD);
        rd(5'h04, v);
        chk(v == 0, "R8 duty held while pending", v, 0);
        wr(5'h08, 32'h0);
        @(negedge clk); en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        rd(5'h04, v);
        chk(v == 32'hABCD, "R8 duty committed", v, 32'hABCD);
    endtask

    task automatic t_left();
        int a, s;
        config_ch(32'h200, 5, 2);
        measure(20, 1'b1, a, s);
        chk(a == 8, "R6 left active cycles", a, 8);
        chk(s == 4, "R4 left period starts", s, 4);
    endtask

    task automatic t_center();
        int a, s;
        config_ch(32'h300, 4, 3);
        measure(32, 1'b1, a, s);
        chk(a == 20, "R6 center duty 3 active", a, 20);
        chk(s == 4, "R5 center period starts", s, 4);
        config_ch(32'h300, 4, 1);
        measure(32, 1'b1, a, s);
        chk(a == 4, "R6 center duty 1 active", a, 4);
    endtask

    task automatic t_edges();
        int a, s;
        config_ch(32'h300, 4, 4);
        measure(32, 1'b1, a, s);
        chk(a == 32, "R7 center duty equals period", a, 32);
        config_ch(32'h200, 5, 5);
        measure(20, 1'b1, a, s);
        chk(a == 20, "R7 left duty equals period", a, 20);
        config_ch(32'h200, 5, 0);
        measure(20, 1'b1, a, s);
        chk(a == 0, "R7 duty zero", a, 0);
    endtask

    task automatic t_presc();
        int a, s;
        logic [31:0] v;
        config_ch(32'h002, 3, 1);
        measure(48, 1'b0, a, s);
        chk(s == 4, "R3 divide by 4", s, 4);
        aux_on = 1'b1;
        config_ch(32'h00B, 2, 1);
        measure(36, 1'b0, a, s);
        chk(s == 6, "R3 aux A ticks", s, 6);
        config_ch(32'h00C, 2, 1);
        measure(20, 1'b0, a, s);
        rd(5'h0C, v);
        chk(s == 0 && v == 0, "R3 aux B idle", v, 0);
        aux_on = 1'b0;
        config_ch(32'h00E, 2, 1);
        measure(20, 1'b0, a, s);
        chk(s == 0, "R3 select 14 no tick", s, 0);
    endtask

    task automatic t_upd_duty();
        int a, s;
        logic [31:0] v;
        config_ch(32'h000, 8, 2);
        wait_start();
        wr(5'h10, 5);
        rd(5'h04, v);
        chk(v == 2, "R8 duty unchanged before start", v, 2);
        wait_start();
        rd(5'h04, v);
        chk(v == 5, "R8 duty after start", v, 5);
        measure(16, 1'b0, a, s);
        chk(a == 10, "R8 new duty waveform", a, 10);
        wr(5'h04, 3);
        wait_start();
        wait_start();
        rd(5'h04, v);
        chk(v == 3, "R10 no second commit", v, 3);
    endtask

    task automatic t_upd_per();
        int a, s;
        logic [31:0] v;
        config_ch(32'h400, 8, 2);
        wait_start();
        wr(5'h10, 6);
        rd(5'h08, v);
        chk(v == 8, "R9 period unchanged before start", v, 8);
        wait_start();
        rd(5'h08, v);
        chk(v == 6, "R9 period after start", v, 6);
        measure(12, 1'b0, a, s);
        chk(s == 2, "R9 new period length", s, 2);
    endtask

    task automatic t_enable();
        int a, s;
        logic [31:0] v;
        config_ch(32'h200, 5, 2);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd(5'h0C, v);
        chk(v == 0, "R11 counter held", v, 0);
        chk(pwm_out == 1'b0, "R11 inactive level", 32'(pwm_out), 0);
        measure(10, 1'b1, a, s);
        chk(s == 0 && a == 0, "R11 no starts while off", s, 0);
        en = 1'b1;
        @(negedge clk);
        rd(5'h0C, v);
        chk(v == 1, "R11 resumes from 0", v, 1);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; aux_on = 1'b0;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_regs();
        t_left();
        t_center();
        t_edges();
        t_presc();
        t_upd_duty();
        t_upd_per();
        t_enable();
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule